// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames on a single input line. Each frame is a low start bit, eight data bits sent least-significant bit first, an optional parity bit that can be set to even or odd, and one stop bit. The line is sampled at sixteen times the bit rate, using a tick from a fixed clock divider. A completed frame lands in a data register. An interrupt pulse marks every rise of the data-full flag.

A CPU reaches the block over a small register bus. Address 0 holds the received byte, address 1 holds status, and address 2 holds control. The status flags are sticky. The CPU can clear a flag only by writing 0 to it after a status read has shown it as 1. While any error flag is set, the receiver stops taking frames. A DMA-style read strobe can also clear the full flag, but only in one DMA configuration. The status register also shows the live line level, so software can tell a break from an ordinary framing error.

Top module: `uart_rx_sticky`

## Requirements
- R1: The line is sampled at 16 ticks per bit. A falling edge starts a frame only if a 2-of-3 majority vote at mid-bit still reads low. Each data bit is a majority vote of three mid-bit samples, and eight bits are assembled least-significant bit first.
- R2: Control bit 1 enables parity and control bit 2 selects odd parity (1) or even parity (0). When the parity bit does not give the selected parity over the data, status bit 3 (parity error) is set.
- R3: A stop bit sampled low sets status bit 2 (framing error).
- R4: A frame with no error sets status bit 0 (data full) and loads the data register. `rx_irq` is high for exactly one clock cycle each time the full flag rises from 0 to 1.
- R5: If the full flag is still 1 when the next frame completes, status bit 1 (overrun) is set, the new frame is discarded and the data register keeps its old value.
- R6: While status bit 1, 2 or 3 is 1, no frame is received: the data register, the full flag and the other flags keep their values.
- R7: A status flag is cleared only by writing 0 to its bit after a status read has returned that bit as 1. Writing 1, or writing 0 without such a read, leaves the flag unchanged.
- R8: A `dma_rd` strobe clears the full flag only when `dma_isel` is 0 and `dma_cnt` is nonzero. `dma_data` always shows the data register.
- R9: Control bit 0 enables reception. When it is 0, no new frame starts, but a frame already in progress completes.
- R10: Status bit 7 reads the current synchronized level of the serial line.
- R11: After reset, the status register reads 0x80 with an idle high line, the data and control registers read 0, and `rx_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high |
| bus_addr | input | ADDR_W | Register address: 0 data, 1 status, 2 control |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Register read data, combinational from `bus_addr` |
| rx_irq | output | 1 | One-cycle pulse when the full flag rises |
| dma_rd | input | 1 | DMA read of the data register |
| dma_isel | input | 1 | DMA interrupt-select mode; 1 stops the automatic clear |
| dma_cnt | input | DMA_CNT_W | DMA remaining transfer count |
| dma_data | output | BUS_W | Data register as seen by the DMA |

## Verification
A vector table sends frames with good data, bad parity, a low stop bit, and both errors together. Data values include all-ones, all-zeros and alternating patterns, which catch bit-order and vote mistakes and show whether each error lands on its own status bit.

Directed sequences then cover four behaviours:
- Two back-to-back unread frames, which separate overrun handling from normal loading.
- A held-low break, which separates the framing flag from the live line bit.
- Odd-parity frames.
- Mid-frame disabling of reception.

The clear rules are checked by writing without a prior read and by writing ones. The three DMA input combinations show that only one of them clears the full flag.

// File: rtl/uart_rx_sticky_pkg.sv
package uart_rx_sticky_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

   // register addresses
   localparam int REG_DATA = 0;
   localparam int REG_STAT = 1;
   localparam int REG_CTRL = 2;

   // status flag positions
   localparam int ST_FULL = 0;
   localparam int ST_OVR  = 1;
   localparam int ST_FER  = 2;
   localparam int ST_PER  = 3;
   localparam int N_FLAGS = 4;

   // control bit positions
   localparam int CT_EN  = 0;
   localparam int CT_PEN = 1;
   localparam int CT_ODD = 2;

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
   parameter int TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   generate
      if (TICK_DIV == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               tick <= 1'b0;
            end else begin
               tick <= (cnt == CW'(TICK_DIV - 1));
               cnt  <= (cnt == CW'(TICK_DIV - 1)) ? '0 : cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_sticky_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic              go,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              par_bad,
   output logic              stop_bad
);
   localparam int SW     = $clog2(OVERSAMPLE);
   localparam int BW     = $clog2(DATA_W);
   localparam int LAST   = OVERSAMPLE - 1;
   localparam int VOTE_A = OVERSAMPLE / 2 - 1;
   localparam int VOTE_B = OVERSAMPLE / 2;
   localparam int VOTE_C = OVERSAMPLE / 2 + 1;

   rx_state_e      state;
   logic [SW-1:0]  cnt;
   logic [BW-1:0]  bitn;
   logic           va, vb, par_acc;
   logic           vote, at_vote, at_last;

   assign vote    = (va & vb) | (va & rx) | (vb & rx);
   assign at_vote = (cnt == SW'(VOTE_C));
   assign at_last = (cnt == SW'(LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         bitn     <= '0;
         va       <= 1'b1;
         vb       <= 1'b1;
         par_acc  <= 1'b0;
         data     <= '0;
         par_bad  <= 1'b0;
         stop_bad <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            if (state != RX_IDLE) cnt <= at_last ? '0 : cnt + 1'b1;
            if (cnt == SW'(VOTE_A)) va <= rx;
            if (cnt == SW'(VOTE_B)) vb <= rx;
            unique case (state)
               RX_IDLE: begin
                  if (go && !rx) begin
                     state <= RX_START;
                     cnt   <= '0;
                  end
               end
               RX_START: begin
                  if (at_vote && vote) begin
                     state <= RX_IDLE;
                  end else if (at_last) begin
                     state   <= RX_DATA;
                     bitn    <= '0;
                     par_acc <= 1'b0;
                     par_bad <= 1'b0;
                  end
               end
               RX_DATA: begin
                  if (at_vote) begin
                     data    <= {vote, data[DATA_W-1:1]};
                     par_acc <= par_acc ^ vote;
                  end else if (at_last) begin
                     if (bitn == BW'(DATA_W - 1))
                        state <= par_en ? RX_PAR : RX_STOP;
                     bitn <= bitn + 1'b1;
                  end
               end
               RX_PAR: begin
                  if (at_vote) par_bad <= ((par_acc ^ vote) != par_odd);
                  else if (at_last) state <= RX_STOP;
               end
               RX_STOP: begin
                  if (at_vote) begin
                     stop_bad <= !vote;
                     done     <= 1'b1;
                     state    <= RX_IDLE;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
   import uart_rx_sticky_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               done,
   input  logic [DATA_W-1:0]  fr_data,
   input  logic               par_bad,
   input  logic               stop_bad,
   input  logic               stat_rd,
   input  logic               stat_wr,
   input  logic [N_FLAGS-1:0] wbits,
   input  logic               dma_clr,
   output logic [N_FLAGS-1:0] flags,
   output logic [DATA_W-1:0]  data_q,
   output logic               irq
);
   logic [N_FLAGS-1:0] armed, set_v, clr_v, flags_n;

   always_comb begin
      set_v = '0;
      clr_v = '0;
      if (done) begin
         if (flags[ST_FULL]) begin
            set_v[ST_OVR] = 1'b1;
         end else begin
            set_v[ST_FER]  = stop_bad;
            set_v[ST_PER]  = par_bad;
            set_v[ST_FULL] = !(stop_bad || par_bad);
         end
      end
      if (stat_wr) clr_v = armed & ~wbits;
      if (dma_clr) clr_v[ST_FULL] = 1'b1;
      flags_n = (flags & ~clr_v) | set_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags  <= '0;
         armed  <= '0;
         data_q <= '0;
         irq    <= 1'b0;
      end else begin
         flags <= flags_n;
         armed <= (stat_rd ? flags : armed) & flags_n;
         irq   <= flags_n[ST_FULL] & ~flags[ST_FULL];
         if (done && !flags[ST_FULL]) data_q <= fr_data;
      end
   end
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky
   import uart_rx_sticky_pkg::*;
#(
   parameter int TICK_DIV   = 4,
   parameter int OVERSAMPLE = 16,
   parameter int DATA_W     = 8,
   parameter int BUS_W      = 8,
   parameter int ADDR_W     = 2,
   parameter int DMA_CNT_W  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_in,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_rd,
   input  logic                 bus_wr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   output logic                 rx_irq,
   input  logic                 dma_rd,
   input  logic                 dma_isel,
   input  logic [DMA_CNT_W-1:0] dma_cnt,
   output logic [BUS_W-1:0]     dma_data
);
   localparam int LINE_BIT = BUS_W - 1;

   generate
      if (OVERSAMPLE < 4) begin : g_bad_os
         $error("OVERSAMPLE must be at least 4");
      end
      if (DATA_W < 2 || DATA_W > BUS_W) begin : g_bad_dw
         $error("DATA_W must lie in 2..BUS_W");
      end
      if (BUS_W < 8) begin : g_bad_bw
         $error("BUS_W must be at least 8");
      end
      if (ADDR_W < 2) begin : g_bad_aw
         $error("ADDR_W must be at least 2");
      end
      if (TICK_DIV < 1) begin : g_bad_td
         $error("TICK_DIV must be at least 1");
      end
   endgenerate

   logic [1:0]         sync;
   logic               line;
   logic [BUS_W-1:0]   ctrl_q;
   logic               tick, frame_done, par_bad, stop_bad, go, any_err;
   logic [DATA_W-1:0]  fr_data, data_q;
   logic [N_FLAGS-1:0] flags;
   logic               stat_rd, stat_wr, dma_clr;

   assign line    = sync[1];
   assign any_err = flags[ST_OVR] | flags[ST_FER] | flags[ST_PER];
   assign go      = ctrl_q[CT_EN] & ~any_err;
   assign stat_rd = bus_rd && (bus_addr == ADDR_W'(REG_STAT));
   assign stat_wr = bus_wr && (bus_addr == ADDR_W'(REG_STAT));
   assign dma_clr = dma_rd && !dma_isel && (dma_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync   <= 2'b11;
         ctrl_q <= '0;
      end else begin
         sync <= {sync[0], rx_in};
         if (bus_wr && bus_addr == ADDR_W'(REG_CTRL)) ctrl_q <= bus_wdata;
      end
   end

   uart_rx_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   uart_rx_frame #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx(line), .go(go),
      .par_en(ctrl_q[CT_PEN]), .par_odd(ctrl_q[CT_ODD]),
      .done(frame_done), .data(fr_data), .par_bad(par_bad), .stop_bad(stop_bad)
   );

   uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .done(frame_done), .fr_data(fr_data),
      .par_bad(par_bad), .stop_bad(stop_bad), .stat_rd(stat_rd),
      .stat_wr(stat_wr), .wbits(bus_wdata[N_FLAGS-1:0]), .dma_clr(dma_clr),
      .flags(flags), .data_q(data_q), .irq(rx_irq)
   );

   assign dma_data = BUS_W'(data_q);

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(REG_DATA): bus_rdata = BUS_W'(data_q);
         ADDR_W'(REG_STAT): begin
            bus_rdata[N_FLAGS-1:0] = flags;
            bus_rdata[LINE_BIT]    = line;
         end
         ADDR_W'(REG_CTRL): bus_rdata = ctrl_q;
         default:           bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/uart_rx_sticky_chk.sv
module uart_rx_sticky_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              full,
   input logic              ovr,
   input logic              any_err,
   input logic [DATA_W-1:0] data_q,
   input logic              irq,
   input logic              dma_rd,
   input logic              dma_isel,
   input logic              stat_wr,
   input logic              wr_full_bit
);
   AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> irq); // R4
   AST_IRQ_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> full); // R4
   AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $stable(data_q)); // R5
   AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      any_err |=> $stable(data_q)); // R6
   AST_WRITE_ONE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wr_full_bit && full && !dma_rd) |=> full); // R7
   AST_DMA_ISEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_rd && dma_isel && full && !stat_wr) |=> full); // R8
endmodule

bind uart_rx_sticky uart_rx_sticky_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .full(flags[0]), .ovr(flags[1]),
   .any_err(any_err), .data_q(data_q), .irq(rx_irq), .dma_rd(dma_rd),
   .dma_isel(dma_isel), .stat_wr(stat_wr), .wr_full_bit(bus_wdata[0])
);

// File: tb/uart_rx_sticky_test.sv
module uart_rx_sticky_test;
   localparam int BIT = 64;  // 4 clocks per tick, 16 ticks per bit

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_in = 1'b1;
   logic [1:0] bus_addr = '0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata, dma_data;
   logic       rx_irq;
   logic       dma_rd = 1'b0, dma_isel = 1'b0;
   logic [7:0] dma_cnt = '0;

   int checks = 0, fails = 0, irq_cnt = 0;
   logic [7:0] rv;

   always #2.5 clk = ~clk;

   uart_rx_sticky uut (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .rx_irq(rx_irq), .dma_rd(dma_rd),
      .dma_isel(dma_isel), .dma_cnt(dma_cnt), .dma_data(dma_data)
   );

   always @(negedge clk) if (rx_irq) irq_cnt++;

   // {data, bad parity, low stop, expected status[3:0]}
   localparam logic [13:0] VEC [8] = '{
      {8'hA5, 1'b0, 1'b0, 4'b0001},
      {8'h3C, 1'b0, 1'b0, 4'b0001},
      {8'h00, 1'b0, 1'b0, 4'b0001},
      {8'hFF, 1'b0, 1'b0, 4'b0001},
      {8'h5A, 1'b1, 1'b0, 4'b1000},
      {8'h81, 1'b0, 1'b1, 4'b0100},
      {8'h7E, 1'b1, 1'b1, 4'b1100},
      {8'h01, 1'b0, 1'b0, 4'b0001}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] d, input logic pen, input logic pbit,
                             input logic stop_v);
      rx_in = 1'b0; wait_clk(BIT);
      for (int i = 0; i < 8; i++) begin rx_in = d[i]; wait_clk(BIT); end
      if (pen) begin rx_in = pbit; wait_clk(BIT); end
      rx_in = stop_v; wait_clk(BIT);
      rx_in = 1'b1; wait_clk(10);
   endtask

   task automatic clear_all();
      logic [7:0] s;
      bus_read(2'd1, s);
      bus_write(2'd1, 8'h00);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int irq0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      // R11 reset state
      bus_read(2'd1, rv); check("R11 status", rv, 8'h80);
      bus_read(2'd0, rv); check("R11 data", rv, 8'h00);
      bus_read(2'd2, rv); check("R11 ctrl", rv, 8'h00);
      check("R11 irq", {7'd0, rx_irq}, 8'h00);

      // R1-style table walk: even parity enabled
      bus_write(2'd2, 8'h03);
      for (int i = 0; i < 8; i++) begin
         logic [7:0] d;
         logic       bp, ls;
         logic [3:0] ex;
         {d, bp, ls, ex} = VEC[i];
         irq0 = irq_cnt;
         send_frame(d, 1'b1, (^d) ^ bp, ~ls);
         bus_read(2'd1, rv); check("R2 R3 R4 status", rv, {4'h8, ex});
         bus_read(2'd0, rv); check("R1 data", rv, d);
         check("R4 irq pulses", 8'(irq_cnt - irq0), {7'd0, ex[0]});
         bus_write(2'd1, 8'h00);
      end
      bus_read(2'd1, rv); check("R7 cleared after table", rv, 8'h80);

      // R3 R10 break: line held low
      send_frame(8'h00, 1'b1, 1'b0, 1'b0);
      rx_in = 1'b0; wait_clk(BIT);
      bus_read(2'd1, rv); check("R10 line low in break", rv, 8'h04);
      rx_in = 1'b1; wait_clk(10);
      bus_read(2'd1, rv); check("R10 line high", rv, 8'h84);
      // R6 framing blocks reception
      send_frame(8'h99, 1'b1, 1'b0, 1'b1);
      bus_read(2'd1, rv); check("R6 fer blocks status", rv, 8'h84);
      bus_read(2'd0, rv); check("R6 fer blocks data", rv, 8'h00);
      clear_all();

      // R5 overrun
      irq0 = irq_cnt;
      send_frame(8'h11, 1'b1, 1'b0, 1'b1);
      send_frame(8'h22, 1'b1, 1'b0, 1'b1);
      bus_read(2'd1, rv); check("R5 overrun status", rv, 8'h83);
      bus_read(2'd0, rv); check("R5 data kept", rv, 8'h11);
      check("R4 one irq for two frames", 8'(irq_cnt - irq0), 8'd1);
      bus_write(2'd1, 8'hFE);  // clear only full
      bus_read(2'd1, rv); check("R7 selective clear", rv, 8'h82);
      // R6 overrun blocks
      send_frame(8'h33, 1'b1, 1'b0, 1'b1);
      bus_read(2'd1, rv); check("R6 ovr blocks status", rv, 8'h82);
      bus_read(2'd0, rv); check("R6 ovr blocks data", rv, 8'h11);
      bus_write(2'd1, 8'h00);
      send_frame(8'h44, 1'b1, 1'b0, 1'b1);
      bus_read(2'd1, rv); check("R6 resumes", rv, 8'h81);
      bus_read(2'd0, rv); check("R6 resumed data", rv, 8'h44);
      bus_write(2'd1, 8'h00);

      // R7 write without read, write of one
      send_frame(8'h55, 1'b1, 1'b0, 1'b1);
      bus_write(2'd1, 8'h00);
      bus_read(2'd1, rv); check("R7 unarmed write", rv, 8'h81);
      bus_write(2'd1, 8'h01);
      bus_read(2'd1, rv); check("R7 write one", rv, 8'h81);

      // R8 DMA clear conditions
      @(negedge clk); dma_isel = 1'b1; dma_cnt = 8'd5; dma_rd = 1'b1;
      @(negedge clk); dma_rd = 1'b0;
      bus_read(2'd1, rv); check("R8 isel=1 keeps", rv, 8'h81);
      @(negedge clk); dma_isel = 1'b0; dma_cnt = 8'd0; dma_rd = 1'b1;
      @(negedge clk); dma_rd = 1'b0;
      bus_read(2'd1, rv); check("R8 count zero keeps", rv, 8'h81);
      check("R8 dma data", dma_data, 8'h55);
      @(negedge clk); dma_cnt = 8'd2; dma_rd = 1'b1;
      @(negedge clk); dma_rd = 1'b0;
      bus_read(2'd1, rv); check("R8 auto clear", rv, 8'h80);

      // R2 odd parity
      bus_write(2'd2, 8'h07);
      send_frame(8'h0F, 1'b1, 1'b1, 1'b1);
      bus_read(2'd1, rv); check("R2 odd good", rv, 8'h81);
      bus_read(2'd0, rv); check("R2 odd data", rv, 8'h0F);
      clear_all();
      send_frame(8'h0F, 1'b1, 1'b0, 1'b1);
      bus_read(2'd1, rv); check("R2 odd bad", rv, 8'h88);
      clear_all();

      // R9 disable mid-frame completes, then ignored; no parity
      bus_write(2'd2, 8'h01);
      fork
         send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
         begin wait_clk(3 * BIT); bus_write(2'd2, 8'h00); end
      join
      bus_read(2'd1, rv); check("R9 in-flight completes", rv, 8'h81);
      bus_read(2'd0, rv); check("R9 in-flight data", rv, 8'hC3);
      clear_all();
      send_frame(8'h3A, 1'b0, 1'b0, 1'b1);
      bus_read(2'd1, rv); check("R9 disabled status", rv, 8'h80);
      bus_read(2'd0, rv); check("R9 disabled data", rv, 8'hC3);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule